// File: doc/BRIEF.md
# Sector-Driven Rectifier Gate Generator

This block produces the six gate signals of a three-phase current-source rectifier stage, which has one upper and one lower bidirectional switch on each input phase. A single up/down counter inside the block forms a symmetrical triangular carrier of fixed amplitude and frequency. That counter value is also exported so that other modulators can share it. An outside controller supplies a 3-bit input-current sector number (1 to 6) and a duty compare value. The block decides which input phase is clamped and which two switches are pulse-width modulated. It then drives those two switches from a single comparison against the carrier, one switch being the exact complement of the other.

In odd sectors the upper switch of the clamped phase stays on for the whole carrier period and the lower switches of the other two phases share the period. In even sectors the lower switch of the clamped phase stays on and the two upper switches of the other phases share it. The sector and compare inputs are captured only when the carrier is at zero, so a period never mixes two settings. With the default parameters and a 100 MHz clock the carrier runs at 10 kHz, which is also the rectifier switching frequency.

Top module: `rect_gate_gen`

## Requirements
- R1: The carrier counts up by one per clock from 0 to CNT_MAX and then down by one per clock back to 0, so one period is 2*CNT_MAX clocks.
- R2: While the synchronous active-high reset `rst` is high, all six gates are off and the carrier is 0. On the first clock after release the carrier steps to 1.
- R3: Phase indices are a=0, b=1, c=2. In odd sectors the upper switch of the clamped phase is on for the whole period: sector 1 clamps a, sector 3 clamps b, sector 5 clamps c.
- R4: In even sectors the lower switch of the clamped phase is on for the whole period: sector 2 clamps c, sector 4 clamps a, sector 6 clamps b.
- R5: The lead phase is the phase after the clamped one in the order a, b, c, a. The trail phase is the one after the lead. The lead switch is on when the carrier value is below the latched compare, and the trail switch is its exact complement. Both are lower switches in odd sectors and upper switches in even sectors. A gate shows the result for a carrier value one clock after the counter held that value.
- R6: A compare of 0 keeps the lead switch off for the whole period. A compare above CNT_MAX keeps it on for the whole period. For a compare c with 1 <= c <= CNT_MAX, the lead switch is on for 2c-1 clocks per period.
- R7: Sector and compare are captured only on the clock where the carrier is 0. Changes at any other time have no effect on the gates until the next such clock.
- R8: Sector values 0 and 7 turn all six gates off.
- R9: No phase ever has its upper and lower switch on together. In a valid sector exactly one upper and exactly one lower switch are on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sectorIn | input | 3 | Input-current sector, 1 to 6 valid |
| cmpIn | input | CMP_W | Duty compare value for the lead switch |
| carrier | output | CNT_W | Current triangular carrier count |
| gateUp | output | 3 | Upper switch gates, bit 0 = phase a |
| gateLo | output | 3 | Lower switch gates, bit 0 = phase a |

## Verification
The bench sweeps every sector code, including the two invalid ones, against every compare from 0 to two above the carrier peak. This exposes a wrong clamp-phase table, a swapped lead/trail rotation, or upper and lower sets that are exchanged between odd and even sectors. A wrong table shows up as a mismatched gate in some sector. The compare extremes and the per-period on-count catch a comparator that is off by one (`<=` in place of `<`), because that gives 2c+1 clocks or misses the always-on case. The seam sample at carrier zero, together with inputs scrambled mid-period, catches capture that happens outside the zero point: that design would change the gates halfway through a period. A reset issued mid-period checks that the gates drop and that counting restarts upward from zero rather than resuming downward.

// File: rtl/rgg_pkg.sv
package rgg_pkg;

  // Number of input phases served by the rectifier stage.
  localparam int unsigned PHASES = 3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clear;     // synchronous reset of all datapath state
    logic latchCfg;  // carrier sits at zero: capture sector and compare
  } rgg_strobe_t;

  // Decoded view of one sector value (one-hot phase masks).
  typedef struct packed {
    logic              valid;    // sector in 1..6
    logic              odd;      // odd sector: upper clamp, lower modulated
    logic [PHASES-1:0] clampOh;  // phase held on
    logic [PHASES-1:0] leadOh;   // phase driven directly by the compare
    logic [PHASES-1:0] trailOh;  // phase driven by the complement
  } rgg_sector_t;

endpackage

// File: rtl/rgg_carrier_ctrl.sv
module rgg_carrier_ctrl
  import rgg_pkg::*;
#(
  parameter int unsigned CNT_MAX = 5000,  // must be at least 2
  parameter int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt,
  output rgg_strobe_t      strobe
);

  localparam logic [CNT_W-1:0] TOP     = CNT_W'(CNT_MAX);
  localparam logic [CNT_W-1:0] NEAR_TOP = CNT_W'(CNT_MAX - 1);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic dirUp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      dirUp <= 1'b1;
    end else if (dirUp) begin
      cnt <= cnt + ONE;
      if (cnt == NEAR_TOP) dirUp <= 1'b0;
    end else begin
      cnt <= cnt - ONE;
      if (cnt == ONE) dirUp <= 1'b1;
    end
  end

  always_comb begin
    strobe.clear    = rst;
    strobe.latchCfg = !rst && (cnt == '0);
  end

  // R1: carrier never leaves its range
  a_r1_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= TOP);

  // R1: every step is exactly one count
  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (cnt == $past(cnt) + ONE) || (cnt == $past(cnt) - ONE));

  // R1: the peak turns the carrier around
  a_r1_turn: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == NEAR_TOP));

  // R2: counting restarts upward from zero after reset
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt == '0) ##1 (cnt == ONE));

endmodule

// File: rtl/rgg_sector_decode.sv
module rgg_sector_decode
  import rgg_pkg::*;
(
  input  logic [2:0]  sector,
  output rgg_sector_t info
);

  logic [PHASES-1:0] clamp;

  always_comb begin
    unique case (sector)
      3'd1, 3'd4: clamp = 3'b001;  // phase a
      3'd2, 3'd5: clamp = 3'b100;  // phase c
      3'd3, 3'd6: clamp = 3'b010;  // phase b
      default:    clamp = 3'b000;
    endcase
  end

  always_comb begin
    info.valid   = (sector != 3'd0) && (sector != 3'd7);
    info.odd     = sector[0];
    info.clampOh = clamp;
    // lead = next phase in a->b->c->a order, trail = the one after it
    info.leadOh  = {clamp[PHASES-2:0], clamp[PHASES-1]};
    info.trailOh = {clamp[0], clamp[PHASES-1:1]};
  end

endmodule

// File: rtl/rgg_gate_datapath.sv
module rgg_gate_datapath
  import rgg_pkg::*;
#(
  parameter int unsigned CNT_W = 13,
  parameter int unsigned CMP_W = 13
) (
  input  logic              clk,
  input  rgg_strobe_t       strobe,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [2:0]        sectorIn,
  input  logic [CMP_W-1:0]  cmpIn,
  output logic [PHASES-1:0] gateUp,
  output logic [PHASES-1:0] gateLo
);

  logic [2:0]        secQ;
  logic [CMP_W-1:0]  cmpQ;
  rgg_sector_t       info;
  logic              hit;
  logic [PHASES-1:0] modMask;
  logic [PHASES-1:0] upNext;
  logic [PHASES-1:0] loNext;

  // configuration capture at the carrier zero point only
  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      secQ <= 3'd0;
      cmpQ <= '0;
    end else if (strobe.latchCfg) begin
      secQ <= sectorIn;
      cmpQ <= cmpIn;
    end
  end

  rgg_sector_decode u_decode (
    .sector (secQ),
    .info   (info)
  );

  assign hit = CMP_W'(cnt) < cmpQ;

  generate
    for (genvar ph = 0; ph < PHASES; ph++) begin : g_phase
      assign modMask[ph] = (info.leadOh[ph] & hit) | (info.trailOh[ph] & !hit);
      assign upNext[ph]  = info.valid & (info.odd ? info.clampOh[ph] : modMask[ph]);
      assign loNext[ph]  = info.valid & (info.odd ? modMask[ph] : info.clampOh[ph]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      gateUp <= '0;
      gateLo <= '0;
    end else begin
      gateUp <= upNext;
      gateLo <= loNext;
    end
  end

  // R7: held configuration moves only on the zero-point strobe
  a_r7_hold_cfg: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.latchCfg |=> $stable(secQ) && $stable(cmpQ));

  // R3: odd sector keeps an upper switch of the clamp phase on
  a_r3_upper_clamp: assert property (@(posedge clk) disable iff (strobe.clear)
    !$past(strobe.clear) && $past(info.valid && info.odd)
      |-> (gateUp & $past(info.clampOh)) != '0);

  // R4: even sector keeps a lower switch of the clamp phase on
  a_r4_lower_clamp: assert property (@(posedge clk) disable iff (strobe.clear)
    !$past(strobe.clear) && $past(info.valid && !info.odd)
      |-> (gateLo & $past(info.clampOh)) != '0);

  // R8: invalid sector codes silence every gate
  a_r8_invalid_off: assert property (@(posedge clk) disable iff (strobe.clear)
    !$past(strobe.clear) && !$past(info.valid) |-> (gateUp == '0) && (gateLo == '0));

  // R9: no phase shorted through its own pair
  a_r9_no_shoot: assert property (@(posedge clk) disable iff (strobe.clear)
    (gateUp & gateLo) == '0);

  // R9: exactly one upper and one lower conducting in valid sectors
  a_r9_one_each: assert property (@(posedge clk) disable iff (strobe.clear)
    !$past(strobe.clear) && $past(info.valid)
      |-> ($countones(gateUp) == 1) && ($countones(gateLo) == 1));

endmodule

// File: rtl/rect_gate_gen.sv
module rect_gate_gen
  import rgg_pkg::*;
#(
  parameter  int unsigned CNT_MAX = 5000,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1),
  localparam int unsigned CMP_W   = $clog2(CNT_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        sectorIn,
  input  logic [CMP_W-1:0]  cmpIn,
  output logic [CNT_W-1:0]  carrier,
  output logic [PHASES-1:0] gateUp,
  output logic [PHASES-1:0] gateLo
);

  rgg_strobe_t strobe;

  rgg_carrier_ctrl #(
    .CNT_MAX (CNT_MAX),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .cnt    (carrier),
    .strobe (strobe)
  );

  rgg_gate_datapath #(
    .CNT_W (CNT_W),
    .CMP_W (CMP_W)
  ) u_data (
    .clk      (clk),
    .strobe   (strobe),
    .cnt      (carrier),
    .sectorIn (sectorIn),
    .cmpIn    (cmpIn),
    .gateUp   (gateUp),
    .gateLo   (gateLo)
  );

endmodule

// File: tb/rect_gate_gen_tb.sv
module rect_gate_gen_tb;

  localparam int MAXC = 8;
  localparam int CW   = $clog2(MAXC + 2);
  localparam int KW   = $clog2(MAXC + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    sectorIn = 3'd0;
  logic [CW-1:0] cmpIn = '0;
  logic [KW-1:0] carrier;
  logic [2:0]    gateUp;
  logic [2:0]    gateLo;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;
  int prevSec  = 0;
  int prevCmp  = 0;

  always #4 clk = ~clk;

  rect_gate_gen #(.CNT_MAX(MAXC)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .sectorIn (sectorIn),
    .cmpIn    (cmpIn),
    .carrier  (carrier),
    .gateUp   (gateUp),
    .gateLo   (gateLo)
  );

  function automatic int clampOf(int sec);
    if (sec == 1 || sec == 4) return 0;
    if (sec == 2 || sec == 5) return 2;
    return 1;
  endfunction

  // expected {gateUp, gateLo} for sector, compare and carrier value
  function automatic logic [5:0] expGates(int sec, int cmp, int c);
    logic [2:0] up;
    logic [2:0] lo;
    int p;
    logic hit;
    up = 3'b000;
    lo = 3'b000;
    if (sec < 1 || sec > 6) return 6'b0;
    p   = clampOf(sec);
    hit = (c < cmp);
    if (sec % 2 == 1) begin
      up[p]         = 1'b1;
      lo[(p+1) % 3] = hit;
      lo[(p+2) % 3] = !hit;
    end else begin
      lo[p]         = 1'b1;
      up[(p+1) % 3] = hit;
      up[(p+2) % 3] = !hit;
    end
    return {up, lo};
  endfunction

  function automatic int triVal(int j);
    if (j <= MAXC) return j;
    return 2 * MAXC - j;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic runPeriod(input int sec, input int cmp, input bit midChange);
    logic [5:0] g;
    logic [5:0] e;
    int onCnt;
    int lead;
    int expOn;
    string tag;
    while (carrier != '0) @(negedge clk);
    sectorIn = sec[2:0];
    cmpIn    = cmp[CW-1:0];
    @(negedge clk);
    // seam sample: value for carrier 0 still belongs to the previous setting
    g = {gateUp, gateLo};
    e = expGates(prevSec, prevCmp, 0);
    chk(g == e, "R7", "seam gates", int'(g), int'(e));
    chk(carrier == KW'(1), "R1", "carrier after zero", int'(carrier), 1);
    tag   = (sec < 1 || sec > 6) ? "R8" : ((sec % 2 == 1) ? "R3 R5" : "R4 R5");
    lead  = (clampOf(sec) + 1) % 3;
    onCnt = 0;
    for (int k = 1; k < 2 * MAXC; k++) begin
      @(negedge clk);
      g = {gateUp, gateLo};
      e = expGates(sec, cmp, triVal(k));
      chk(g == e, tag, "gates", int'(g), int'(e));
      chk((gateUp & gateLo) == 3'b000, "R9", "phase overlap", int'(gateUp & gateLo), 0);
      chk(int'(carrier) == triVal(k + 1), "R1", "carrier", int'(carrier), triVal(k + 1));
      if (sec % 2 == 1) onCnt += int'(gateLo[lead]);
      else              onCnt += int'(gateUp[lead]);
      if (midChange && k == MAXC) begin
        // scrambled mid-period inputs must not reach the gates (R7)
        sectorIn = 3'(sec ^ 3);
        cmpIn    = (cmp == 0) ? CW'(MAXC + 1) : '0;
      end
    end
    if (sec >= 1 && sec <= 6) begin
      // on-count over carrier values 1..MAXC..1 (the zero value lies in the seam)
      if (cmp == 0)         expOn = 0;
      else if (cmp <= MAXC) expOn = 2 * (cmp - 1);
      else                  expOn = 2 * MAXC - 1;
      chk(onCnt == expOn, "R6", "lead on-count", onCnt, expOn);
    end
    sectorIn = sec[2:0];
    cmpIn    = cmp[CW-1:0];
    prevSec  = sec;
    prevCmp  = cmp;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({gateUp, gateLo} == 6'b0, "R2", "gates in reset", int'({gateUp, gateLo}), 0);
    chk(carrier == '0, "R2", "carrier in reset", int'(carrier), 0);
    rst = 1'b0;
    // first period also shows the count restarting upward (R2)
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c <= MAXC + 2; c++) begin
        runPeriod(s, c, c == 3);
      end
    end
    runPeriod(1, 5, 1'b1);
    // reset in the middle of a period
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk({gateUp, gateLo} == 6'b0, "R2", "gates after mid reset", int'({gateUp, gateLo}), 0);
    chk(carrier == '0, "R2", "carrier after mid reset", int'(carrier), 0);
    rst     = 1'b0;
    prevSec = 0;
    prevCmp = 0;
    runPeriod(6, 2, 1'b0);
    runPeriod(3, 7, 1'b0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule